// File: doc/BRIEF.md
# SCL/SDA Pin Function Override

This block sits between an I2C controller core and the two bus pads. In normal operation it passes the core's open-drain pull-down requests straight through to the SCL and SDA pads. Software can instead take both pads away from the core with one mode bit and drive them as general-purpose pins. This is typically used to toggle SCL by hand until a slave that is holding SDA low lets go. The recovery routine itself runs in software and is not part of this block.

In override mode, each pad has a direction bit and an output latch. The latch is never written directly. Bits are raised through a write-one-to-set register and lowered through a write-one-to-clear register, so software cannot disturb the other pin while changing one. Both pads are open-drain: a 1 in the latch releases the line, and a 0 pulls it low.

The pad levels are always readable through a pin-level register. Each pad passes through a two-flop synchroniser before it reaches that register.

Top module: `i2c_pin_override`

## Requirements
- R1: After reset, the mode bit and both direction bits are 0, the output latch reads 2'b11, and the pads follow the core's drive inputs.
- R2: Bit 0 of the mode register (address 0) moves both pads to general-purpose control at once. Clearing it returns both pads to the core. Other written bits are discarded and read back as 0.
- R3: Direction register (address 1): bit 0 makes SCL an output and bit 1 makes SDA an output. A 0 bit means input.
- R4: Writing the set register (address 4) raises each latch bit whose written bit is 1 (bit 0 = SCL, bit 1 = SDA). Latch bits written with 0 keep their value.
- R5: Writing the clear register (address 5) lowers each latch bit whose written bit is 1 (bit 0 = SCL, bit 1 = SDA). Latch bits written with 0 keep their value.
- R6: In general-purpose mode, a pad configured as output is pulled low (pull output 1) when its latch bit is 0 and released when it is 1.
- R7: In general-purpose mode, a pad configured as input is released whatever its latch bit holds.
- R8: The pin-level register (address 2) reports SCL in bit 0 and SDA in bit 1. A pad level present before clock edge k is readable after edge k+1 and not before.
- R9: In core mode, each pull output equals the core's drive input for that pad. Direction and latch contents have no effect on the pads.
- R10: The output latch reads back at address 3. The set and clear addresses, and unused addresses, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| core_scl_low | input | 1 | Core requests SCL pulled low |
| core_sda_low | input | 1 | Core requests SDA pulled low |
| scl_pad_in | input | 1 | Sensed SCL pad level |
| sda_pad_in | input | 1 | Sensed SDA pad level |
| scl_pull_low | output | 1 | Pull-down enable for the SCL pad |
| sda_pull_low | output | 1 | Pull-down enable for the SDA pad |

## Verification
The assertions assume that reg_addr and reg_wdata are settled whenever reg_wr is high. They also assume that the pad inputs are ordinary levels that change at most once per clock cycle. The bench drives every input on the falling clock edge, so the register and synchroniser flops see stable values.

The bench models each pad as a wired-AND of the block's pull output and an external pull-down. This keeps the sensed level consistent with the block's own drive, as a real open-drain line would be.

// File: rtl/pin_override_pkg.sv
package pin_override_pkg;

    localparam int NPIN    = 2;
    localparam int PIN_SCL = 0;
    localparam int PIN_SDA = 1;

    typedef enum logic [2:0] {
        SEL_MODE  = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_LEVEL = 3'd2,
        SEL_LATCH = 3'd3,
        SEL_SET   = 3'd4,
        SEL_CLR   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic            gpio_mode;
        logic [NPIN-1:0] dir_out;
        logic [NPIN-1:0] latch;
    } pin_ctrl_t;

    // Open-drain pull request for one pad in general-purpose mode.
    function automatic logic od_pull(input logic is_out, input logic level);
        return is_out & ~level;
    endfunction

    // Apply set and clear masks to the output latch.
    function automatic logic [NPIN-1:0] latch_next(input logic [NPIN-1:0] cur,
                                                   input logic [NPIN-1:0] set_m,
                                                   input logic [NPIN-1:0] clr_m);
        return (cur | set_m) & ~clr_m;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync
    import pin_override_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] level_q
);
    logic [NPIN-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '1;
                end else if (s == 0) begin
                    stage_q[s] <= pad_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign level_q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_regs.sv
module pin_regs
    import pin_override_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NPIN-1:0]   pin_level,
    output logic [DATA_W-1:0] reg_rdata,
    output pin_ctrl_t         ctrl
);
    localparam int PAD_W = DATA_W - NPIN;

    pin_ctrl_t       ctrl_q;
    logic            hit_mode, hit_dir, hit_set, hit_clr;
    logic [NPIN-1:0] set_m, clr_m;

    assign hit_mode = reg_wr && (reg_addr == ADDR_W'(SEL_MODE));
    assign hit_dir  = reg_wr && (reg_addr == ADDR_W'(SEL_DIR));
    assign hit_set  = reg_wr && (reg_addr == ADDR_W'(SEL_SET));
    assign hit_clr  = reg_wr && (reg_addr == ADDR_W'(SEL_CLR));
    assign set_m    = hit_set ? reg_wdata[NPIN-1:0] : '0;
    assign clr_m    = hit_clr ? reg_wdata[NPIN-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.gpio_mode <= 1'b0;
            ctrl_q.dir_out   <= '0;
            ctrl_q.latch     <= '1;
        end else begin
            if (hit_mode) ctrl_q.gpio_mode <= reg_wdata[0];
            if (hit_dir)  ctrl_q.dir_out   <= reg_wdata[NPIN-1:0];
            ctrl_q.latch <= latch_next(ctrl_q.latch, set_m, clr_m);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(SEL_MODE):  reg_rdata[0] = ctrl_q.gpio_mode;
            ADDR_W'(SEL_DIR):   reg_rdata = {{PAD_W{1'b0}}, ctrl_q.dir_out};
            ADDR_W'(SEL_LEVEL): reg_rdata = {{PAD_W{1'b0}}, pin_level};
            ADDR_W'(SEL_LATCH): reg_rdata = {{PAD_W{1'b0}}, ctrl_q.latch};
            default:            reg_rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/pin_mux.sv
module pin_mux
    import pin_override_pkg::*;
(
    input  pin_ctrl_t       ctrl,
    input  logic [NPIN-1:0] core_low,
    output logic [NPIN-1:0] pull_low
);
    genvar p;
    generate
        for (p = 0; p < NPIN; p++) begin : g_pin
            assign pull_low[p] = ctrl.gpio_mode
                               ? od_pull(ctrl.dir_out[p], ctrl.latch[p])
                               : core_low[p];
        end
    endgenerate
endmodule

// File: rtl/i2c_pin_override.sv
module i2c_pin_override
    import pin_override_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              core_scl_low,
    input  logic              core_sda_low,
    input  logic              scl_pad_in,
    input  logic              sda_pad_in,
    output logic              scl_pull_low,
    output logic              sda_pull_low
);
    pin_ctrl_t       ctrl;
    logic [NPIN-1:0] pin_level;
    logic [NPIN-1:0] pad_vec;
    logic [NPIN-1:0] core_vec;
    logic [NPIN-1:0] pull_vec;

    assign pad_vec[PIN_SCL]  = scl_pad_in;
    assign pad_vec[PIN_SDA]  = sda_pad_in;
    assign core_vec[PIN_SCL] = core_scl_low;
    assign core_vec[PIN_SDA] = core_sda_low;

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_vec),
        .level_q (pin_level)
    );

    pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pin_level (pin_level),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl)
    );

    pin_mux u_mux (
        .ctrl     (ctrl),
        .core_low (core_vec),
        .pull_low (pull_vec)
    );

    assign scl_pull_low = pull_vec[PIN_SCL];
    assign sda_pull_low = pull_vec[PIN_SDA];
endmodule

// File: rtl/i2c_pin_override_chk.sv
module i2c_pin_override_chk
    import pin_override_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              core_scl_low,
    input logic              core_sda_low,
    input logic              scl_pad_in,
    input logic              sda_pad_in,
    input logic              scl_pull_low,
    input logic              sda_pull_low,
    input pin_ctrl_t         ctrl,
    input logic [NPIN-1:0]   pin_level
);
    logic [1:0] settle_q;

    always_ff @(posedge clk) begin
        if (rst)                 settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    // R9: core mode passes the core drives straight to the pads
    p_core_pass_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.gpio_mode |-> (scl_pull_low == core_scl_low && sda_pull_low == core_sda_low));

    // R7: input pads are released in override mode
    p_input_released_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.gpio_mode && !ctrl.dir_out[PIN_SCL]) |-> !scl_pull_low);

    // R6: output pad pulled low exactly when latch is 0
    p_od_drive_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.gpio_mode && ctrl.dir_out[PIN_SDA]) |-> (sda_pull_low == !ctrl.latch[PIN_SDA]));

    // R4: a set write raises the latch bit
    p_set_raises_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(SEL_SET) && reg_wdata[PIN_SCL]) |=> ctrl.latch[PIN_SCL]);

    // R5: a clear write lowers the latch bit
    p_clr_lowers_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(SEL_CLR) && reg_wdata[PIN_SDA]) |=> !ctrl.latch[PIN_SDA]);

    // R4: latch holds when neither set nor clear is written
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && (reg_addr == ADDR_W'(SEL_SET) || reg_addr == ADDR_W'(SEL_CLR)))
        |=> $stable(ctrl.latch));

    // R8: synchronised level lags the pad by two edges
    p_sync_lag_r8: assert property (@(posedge clk) disable iff (rst)
        (settle_q == 2'd3) |-> (pin_level[PIN_SCL] == $past(scl_pad_in, 2)
                              && pin_level[PIN_SDA] == $past(sda_pad_in, 2)));
endmodule

bind i2c_pin_override i2c_pin_override_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .core_scl_low (core_scl_low),
    .core_sda_low (core_sda_low),
    .scl_pad_in   (scl_pad_in),
    .sda_pad_in   (sda_pad_in),
    .scl_pull_low (scl_pull_low),
    .sda_pull_low (sda_pull_low),
    .ctrl         (ctrl),
    .pin_level    (pin_level)
);

// File: tb/test_i2c_pin_override.sv
`timescale 1ns/1ps
module test_i2c_pin_override;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              core_scl_low = 1'b0;
    logic              core_sda_low = 1'b0;
    logic              scl_pull_low, sda_pull_low;
    logic              ext_scl_low = 1'b0;
    logic              ext_sda_low = 1'b0;
    logic              scl_pad_in, sda_pad_in;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    assign scl_pad_in = !(scl_pull_low || ext_scl_low);
    assign sda_pad_in = !(sda_pull_low || ext_sda_low);

    i2c_pin_override #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_i2c_pin_override (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .core_scl_low (core_scl_low),
        .core_sda_low (core_sda_low),
        .scl_pad_in   (scl_pad_in),
        .sda_pad_in   (sda_pad_in),
        .scl_pull_low (scl_pull_low),
        .sda_pull_low (sda_pull_low)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        rd(3'd0, d); check("R1 mode", d, 0);
        rd(3'd1, d); check("R1 dir", d, 0);
        rd(3'd3, d); check("R1 latch", d, 8'h03);
        check("R1 pads", {scl_pull_low, sda_pull_low}, 2'b00);
        rd(3'd4, d); check("R10 set reads 0", d, 0);
        rd(3'd5, d); check("R10 clr reads 0", d, 0);
        rd(3'd7, d); check("R10 unused reads 0", d, 0);
    endtask

    task automatic t_core_pass();
        core_scl_low = 1'b1; core_sda_low = 1'b0; #1;
        check("R9 core scl", {scl_pull_low, sda_pull_low}, 2'b10);
        core_scl_low = 1'b0; core_sda_low = 1'b1; #1;
        check("R9 core sda", {scl_pull_low, sda_pull_low}, 2'b01);
        core_sda_low = 1'b0;
        wr(3'd1, 8'h03);
        wr(3'd5, 8'h03);
        #1;
        check("R9 dir/latch ignored", {scl_pull_low, sda_pull_low}, 2'b00);
        wr(3'd4, 8'h03);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_mode();
        logic [DATA_W-1:0] d;
        core_scl_low = 1'b1; core_sda_low = 1'b1;
        wr(3'd0, 8'hFF);
        rd(3'd0, d); check("R2 mode readback", d, 8'h01);
        check("R2 both pads leave core", {scl_pull_low, sda_pull_low}, 2'b00);
        wr(3'd0, 8'hFE);
        #1;
        check("R2 return to core", {scl_pull_low, sda_pull_low}, 2'b11);
        core_scl_low = 1'b0; core_sda_low = 1'b0;
    endtask

    task automatic t_drive();
        logic [DATA_W-1:0] d;
        wr(3'd0, 8'h01);
        wr(3'd1, 8'h01);
        rd(3'd1, d); check("R3 dir readback", d, 8'h01);
        wr(3'd5, 8'h03);
        #1;
        check("R6 scl driven low", scl_pull_low, 1'b1);
        check("R7 sda input released", sda_pull_low, 1'b0);
        wr(3'd1, 8'h02);
        #1;
        check("R3 sda output low", {scl_pull_low, sda_pull_low}, 2'b01);
        wr(3'd4, 8'h02);
        #1;
        check("R6 sda released by latch 1", sda_pull_low, 1'b0);
    endtask

    task automatic t_set_clr();
        logic [DATA_W-1:0] d;
        rd(3'd3, d); check("R4 latch before", d, 8'h02);
        wr(3'd4, 8'h00);
        rd(3'd3, d); check("R4 zero set no effect", d, 8'h02);
        wr(3'd4, 8'h01);
        rd(3'd3, d); check("R4 set scl", d, 8'h03);
        wr(3'd5, 8'h00);
        rd(3'd3, d); check("R5 zero clr no effect", d, 8'h03);
        wr(3'd5, 8'h02);
        rd(3'd3, d); check("R5 clr sda", d, 8'h01);
        wr(3'd4, 8'h03);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_sync();
        logic [DATA_W-1:0] d;
        @(negedge clk);
        ext_sda_low = 1'b1;
        @(negedge clk);
        rd(3'd2, d); check("R8 not after one edge", d, 8'h03);
        @(negedge clk);
        rd(3'd2, d); check("R8 sda after two edges", d, 8'h01);
        ext_sda_low = 1'b0; ext_scl_low = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd2, d); check("R8 scl low", d, 8'h02);
        ext_scl_low = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(3'd2, d); check("R8 both high", d, 8'h03);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_core_pass();
        t_mode();
        t_drive();
        t_set_clr();
        t_sync();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule